// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block counts clock cycles while software keeps the watchdog enabled. Before the selected period runs out, software must prove that it is still alive by writing two key bytes to an arm register, 0x55 first and 0xAA second. A complete pair restarts the count from zero. If the count reaches the end of the period first, or if software writes a value that is not one of the two keys, the block raises a reset request for the rest of the chip.

A two-bit select picks one of four periods, each four times longer than the one before. With the default parameters these are 2^14, 2^16, 2^18 and 2^20 clock cycles. While the enable is low the counter stays at zero and the arm register has no effect. Once raised, the reset request stays high until the block itself is reset.

Top module: `keyed_wdt`

## Requirements
- R1: After rst_n is released, rst_req is 0 and the count starts from zero.
- R2: While wd_en is 0, the counter is held at zero, arm writes of any value are ignored, and rst_req does not rise.
- R3: The period in cycles is 2^(BASE_EXP + 2*period_sel): 2^14, 2^16, 2^18 or 2^20 by default. With no restart, rst_req rises at the clock edge that completes that many consecutive enabled cycles.
- R4: An arm write of 0xAA while the sequence is armed by an earlier 0x55 restarts the count. The next expiry then falls a full period after the edge that took the 0xAA.
- R5: An arm write of 0xAA with no pending 0x55 neither restarts the count nor raises rst_req.
- R6: An enabled arm write of any byte other than 0x55 or 0xAA sets rst_req at the same clock edge.
- R7: Once set, rst_req stays high whatever wd_en, period_sel or the arm writes do, until rst_n is asserted.
- R8: Repeated 0x55 writes keep the sequence armed. A completed pair uses up the arming, so a second 0xAA on its own does not restart the count.
- R9: If period_sel is changed to a period shorter than the count already reached, the watchdog expires at the next enabled edge.
- R10: A completed key pair on the very edge at which the period would expire wins: no reset request is raised, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| wd_en | input | 1 | Watchdog enable |
| period_sel | input | 2 | Time-out period select |
| arm_we | input | 1 | Write strobe for the arm register |
| arm_wdata | input | 8 | Byte written to the arm register |
| rst_req | output | 1 | Sticky reset request |

## Verification
The assertions check on every cycle that:
- the counter is cleared while disabled and after a valid key pair;
- a bad key or an unserviced expiry sets the request at the next edge;
- the request never drops before reset and never rises without one of those two causes;
- a lone 0xAA never counts as a service.

Only the bench scenarios can show the exact length of each selectable period and the full-period gap after a service. They also cover the armed state surviving repeated 0x55 writes, the race between service and expiry, and the early expiry after shortening the period. The bench tests these with directed sequences and then with a random mix of writes against its own model.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  // Exponent of the period chosen by a select value.
  function automatic int unsigned period_exp(input int unsigned base_exp,
                                             input int unsigned step_exp,
                                             input int unsigned sel);
    return base_exp + step_exp * sel;
  endfunction

  // True when a written byte is one of the two service keys.
  function automatic logic is_key(input logic [7:0] b);
    return (b == KEY_FIRST) || (b == KEY_SECOND);
  endfunction

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic       key_ok,
  output logic       key_bad,
  output logic       armed
);

  key_state_e state_q, state_d;

  assign armed   = (state_q == KS_ARMED);
  assign key_ok  = enable && we && (wdata == KEY_SECOND) && armed;
  assign key_bad = enable && we && !is_key(wdata);

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = KS_IDLE;
    end else if (we) begin
      if (wdata == KEY_FIRST) state_d = KS_ARMED;
      else                    state_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 14,
  parameter int unsigned STEP_EXP = 2,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned CNT_W    = BASE_EXP + STEP_EXP * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);

  localparam int unsigned NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] term_tbl [NSEL];

  // One terminal value per select setting: 2^exp - 1.
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    localparam int unsigned EXP = period_exp(BASE_EXP, STEP_EXP, g);
    assign term_tbl[g] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  // Greater-or-equal so that shortening the period never skips expiry.
  assign expire = enable && (cnt_q >= term_tbl[sel]);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!enable)           cnt_q <= '0;
    else if (restart || expire) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 14,
  parameter int unsigned STEP_EXP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_en,
  input  logic [1:0] period_sel,
  input  logic       arm_we,
  input  logic [7:0] arm_wdata,
  output logic       rst_req
);

  localparam int unsigned SEL_W = 2;
  localparam int unsigned CNT_W = BASE_EXP + STEP_EXP * ((1 << SEL_W) - 1);

  logic             key_ok;
  logic             key_bad;
  logic             armed;
  logic             expire;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  kwdt_keyseq u_keys (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (wd_en),
    .we     (arm_we),
    .wdata  (arm_wdata),
    .key_ok (key_ok),
    .key_bad(key_bad),
    .armed  (armed)
  );

  kwdt_counter #(
    .BASE_EXP(BASE_EXP),
    .STEP_EXP(STEP_EXP),
    .SEL_W   (SEL_W),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (wd_en),
    .sel    (period_sel),
    .restart(key_ok),
    .expire (expire),
    .cnt_q  (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                             req_q <= 1'b0;
    else if (key_bad || (expire && !key_ok)) req_q <= 1'b1;
  end

  assign rst_req = req_q;

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wd_en,
  input logic             arm_we,
  input logic [7:0]       arm_wdata,
  input logic             key_ok,
  input logic             key_bad,
  input logic             armed,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rst_req
);

  p_hold_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (cnt_q == '0));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> (cnt_q == '0));

  p_lone_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && arm_we && arm_wdata == 8'hAA && !armed) |-> !key_ok);

  p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && arm_we && arm_wdata != 8'h55 && arm_wdata != 8'hAA) |=> rst_req);

  p_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !key_ok) |=> rst_req);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  p_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(key_bad || expire));

  p_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && !$past(rst_req) && !rst_req) |=> !rst_req);

endmodule

bind keyed_wdt kwdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wd_en    (wd_en),
  .arm_we   (arm_we),
  .arm_wdata(arm_wdata),
  .key_ok   (key_ok),
  .key_bad  (key_bad),
  .armed    (armed),
  .expire   (expire),
  .cnt_q    (cnt_q),
  .rst_req  (rst_req)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

  localparam int unsigned BASE = 6;
  localparam int unsigned STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wd_en = 1'b0;
  logic [1:0] period_sel = 2'd0;
  logic       arm_we = 1'b0;
  logic [7:0] arm_wdata = 8'h00;
  logic       rst_req;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  int unsigned m_cnt = 0;
  bit          m_armed = 0;
  bit          m_req = 0;

  always #10 clk = ~clk;

  keyed_wdt #(.BASE_EXP(BASE), .STEP_EXP(STEP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_en     (wd_en),
    .period_sel(period_sel),
    .arm_we    (arm_we),
    .arm_wdata (arm_wdata),
    .rst_req   (rst_req)
  );

  function automatic int unsigned limit_of(input int unsigned sel);
    int unsigned p = 1;
    for (int i = 0; i < BASE + STEP * sel; i++) p = p * 2;
    return p;
  endfunction

  function automatic void model_step(input bit en, input int unsigned sel,
                                     input bit we, input logic [7:0] d);
    bit svc, bad, exp;
    if (!en) begin
      m_cnt = 0; m_armed = 0;
      return;
    end
    svc = we && d == 8'hAA && m_armed;
    bad = we && d != 8'h55 && d != 8'hAA;
    exp = (m_cnt + 1 >= limit_of(sel));
    if (bad || (exp && !svc)) m_req = 1;
    if (svc || exp) m_cnt = 0; else m_cnt = m_cnt + 1;
    if (we) m_armed = (d == 8'h55);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rst_req=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: inputs are stable from the previous negedge.
  task automatic step();
    @(posedge clk);
    model_step(wd_en, period_sel, arm_we, arm_wdata);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] d);
    arm_we = 1'b1; arm_wdata = d;
    step();
    arm_we = 1'b0; arm_wdata = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wd_en = 1'b0; arm_we = 1'b0; period_sel = 2'd0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_armed = 0; m_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned lim;
    void'($urandom(32'h5EED_0C0D));
    @(negedge clk);
    do_reset();
    check(rst_req, 1'b0, "R1 reset state");

    // R2: disabled, writes of bad and good bytes ignored
    for (int i = 0; i < 600; i++) begin
      arm_we = (i % 3 == 0); arm_wdata = (i % 2) ? 8'h3C : 8'hAA;
      step();
    end
    arm_we = 1'b0;
    check(rst_req, 1'b0, "R2 disabled ignores writes");

    // R3: each period, boundary on both sides; R1 clears after request
    for (int s = 0; s < 4; s++) begin
      do_reset();
      check(rst_req, 1'b0, "R1 cleared by reset");
      period_sel = 2'(s); wd_en = 1'b1;
      lim = limit_of(s);
      idle(lim - 1);
      check(rst_req, 1'b0, "R3 before period end");
      step();
      check(rst_req, 1'b1, "R3 at period end");
    end

    // R4: service restarts full period
    do_reset(); wd_en = 1'b1;
    idle(30); wr(8'h55); idle(10); wr(8'hAA);
    idle(63);
    check(rst_req, 1'b0, "R4 no expiry a cycle before full period");
    step();
    check(rst_req, 1'b1, "R4 expiry a full period after service");

    // R5: lone 0xAA no restart, no request
    do_reset(); wd_en = 1'b1;
    idle(39); wr(8'hAA);
    check(rst_req, 1'b0, "R5 lone second key no request");
    idle(23);
    check(rst_req, 1'b0, "R5 before original expiry");
    step();
    check(rst_req, 1'b1, "R5 original expiry kept");

    // R6: bad byte, request at the same edge
    do_reset(); wd_en = 1'b1;
    idle(5);
    check(rst_req, 1'b0, "R6 before bad write");
    wr(8'h3C);
    check(rst_req, 1'b1, "R6 bad write sets request");

    // R7: sticky through disable, select changes, writes
    wd_en = 1'b0; period_sel = 2'd3; idle(20);
    wd_en = 1'b1; wr(8'h55); wr(8'hAA); idle(5);
    check(rst_req, 1'b1, "R7 request sticky");
    do_reset();
    check(rst_req, 1'b0, "R7 cleared only by reset");

    // R8: repeated first key, then pair consumed
    wd_en = 1'b1;
    idle(20); wr(8'h55); wr(8'h55); idle(3); wr(8'hAA);   // restart at this edge
    idle(40); wr(8'hAA);                                   // edge 41 after restart: no restart
    idle(22);
    check(rst_req, 1'b0, "R8 before expiry");
    step();
    check(rst_req, 1'b1, "R8 second lone AA did not restart");

    // R9: shorten period below current count
    do_reset(); wd_en = 1'b1; period_sel = 2'd3;
    idle(300);
    check(rst_req, 1'b0, "R9 long period still running");
    period_sel = 2'd0;
    step();
    check(rst_req, 1'b1, "R9 expiry at next edge");

    // R10: service on the expiry edge
    do_reset(); wd_en = 1'b1;
    wr(8'h55); idle(62); wr(8'hAA);   // 64th enabled edge
    check(rst_req, 1'b0, "R10 service wins race");
    idle(63);
    check(rst_req, 1'b0, "R10 restarted count");
    step();
    check(rst_req, 1'b1, "R10 next expiry");

    // Random phase against the model (R3 R4 R5 R6 R8)
    for (int ep = 0; ep < 25; ep++) begin
      do_reset();
      period_sel = 2'($urandom % 2); wd_en = 1'b1;
      for (int c = 0; c < 400; c++) begin
        int unsigned r = $urandom % 100;
        arm_we = 1'b0;
        if (r < 6)       begin arm_we = 1'b1; arm_wdata = 8'h55; end
        else if (r < 12) begin arm_we = 1'b1; arm_wdata = 8'hAA; end
        else if (r == 12) begin arm_we = 1'b1; arm_wdata = 8'($urandom); end
        else if (r > 97) wd_en = ~wd_en;
        step();
        check(rst_req, m_req, "R3/R4/R6 random vs model");
      end
      arm_we = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule